// File: doc/BRIEF.md
# Reverse-Subtract-and-Skip-if-Borrow Processor Core

This core runs programs built from a single instruction. Each program word is an operand address A. Executing it subtracts the accumulator from the word at A. The difference goes both to that word and to the accumulator. When the difference is negative, the following program word is passed over. The instruction pointer lives at memory word 0 and the accumulator at memory word 1. A program therefore jumps by using word 0 as its operand, and clears the accumulator by using word 1. Two operand codes are reserved. All ones is a no-operation. All ones except bit 0 halts the core.

The core drives one synchronous single-port memory. Read data appears one clock after its address. After reset the core loads its instruction pointer from word 0 and its accumulator from word 1, so the loader chooses the entry point and the starting accumulator. Before every fetch the core writes both register images back to words 0 and 1, so memory and registers never disagree when a program reads them.

Top module: `rssb_core`

## Requirements
- R1: While `rst_n` is low, `halted` is 0 and `memWe` is 0.
- R2: After reset, the first instruction is fetched from the address held in memory word 0, with the accumulator taken from memory word 1.
- R3: An instruction with operand A (not 0 or 1) writes mem[A] − ACC, in 16-bit two's complement with wraparound, to word A and to the accumulator (word 1).
- R4: If bit 15 of the result is 1, the next fetch is at IP+2; otherwise it is at IP+1. A zero result is not negative.
- R5: Operand 1 subtracts the accumulator from itself, leaving 0 in the accumulator and word 1.
- R6: Operand 0 uses the live IP as the minuend, and the result becomes the new IP with no increment or skip added.
- R7: Instruction word 16'hFFFF advances IP by 1 and leaves the accumulator and all other memory words unchanged.
- R8: Instruction word 16'hFFFE raises `halted`, which stays high until reset. While halted the core makes no memory writes, and word 0 holds the halting address.
- R9: Whenever an instruction is fetched, word 0 holds the current IP and word 1 the current accumulator, including when the fetch itself reads word 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| memAddr | output | 16 | Memory word address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid one cycle after its address |
| halted | output | 1 | High once a halt word has been fetched |

## Verification
The register images are the hazard here. A stale accumulator or IP shows at the ports within one instruction: a wrong write to the operand word, a wrong value in word 1, or a fetch at the wrong address. A wrong fetch address usually runs into a halt word at an unexpected IP, or never halts at all. The programs place halt words on both the skip and the no-skip paths, and on both sides of a jump target. An off-by-one in IP selection therefore ends with an unexpected value in word 0. One program executes an instruction out of word 1 itself, so a missing accumulator write-back changes the path the program takes.

// File: rtl/rssb_pkg.sv
package rssb_pkg;

  typedef enum logic [1:0] {
    ADDR_IP,
    ADDR_OP,
    ADDR_IPWORD,
    ADDR_ACCWORD
  } addrSel_t;

  typedef enum logic [1:0] {
    WD_RES,
    WD_ACC,
    WD_IP
  } wdSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     bootIp;
    logic     bootAcc;
    logic     latchOp;
    logic     exec;
    logic     stepNop;
    addrSel_t addrSel;
    wdSel_t   wdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/rssb_datapath.sv
module rssb_datapath
  import rssb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       st,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdIsHalt,
  output logic              rdIsNop
);

  localparam logic [DATA_W-1:0] IP_WORD   = '0;
  localparam logic [DATA_W-1:0] ACC_WORD  = DATA_W'(1);
  localparam logic [DATA_W-1:0] NOP_CODE  = '1;
  localparam logic [DATA_W-1:0] HALT_CODE = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] STEP_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP_TWO  = DATA_W'(2);

  logic [DATA_W-1:0] ipReg, accReg, opReg;
  logic [DATA_W-1:0] operand, result, nextIp;

  assign rdIsHalt = (memRdata == HALT_CODE);
  assign rdIsNop  = (memRdata == NOP_CODE);

  // operands 0 and 1 read the live register, not the memory image
  always_comb begin
    if (opReg == IP_WORD)       operand = ipReg;
    else if (opReg == ACC_WORD) operand = accReg;
    else                        operand = memRdata;
  end

  assign result = operand - accReg;
  assign nextIp = (opReg == IP_WORD) ? result
                : ipReg + (result[DATA_W-1] ? STEP_TWO : STEP_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipReg  <= '0;
      accReg <= '0;
      opReg  <= '0;
    end else begin
      if (st.bootIp)  ipReg   <= memRdata;
      if (st.bootAcc) accReg  <= memRdata;
      if (st.latchOp) opReg   <= memRdata;
      if (st.stepNop) ipReg   <= ipReg + STEP_ONE;
      if (st.exec) begin
        accReg <= result;
        ipReg  <= nextIp;
      end
    end
  end

  always_comb begin
    unique case (st.addrSel)
      ADDR_IP:      memAddr = ipReg;
      ADDR_OP:      memAddr = opReg;
      ADDR_IPWORD:  memAddr = IP_WORD;
      ADDR_ACCWORD: memAddr = ACC_WORD;
      default:      memAddr = ipReg;
    endcase
  end

  always_comb begin
    unique case (st.wdSel)
      WD_RES:  memWdata = result;
      WD_ACC:  memWdata = accReg;
      WD_IP:   memWdata = ipReg;
      default: memWdata = result;
    endcase
  end

  // R5: self-subtraction of the accumulator leaves zero
  p_acc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.exec && opReg == ACC_WORD) |=> (accReg == '0));

  // R6: a write to word 0 lands in IP exactly, same value as ACC
  p_jump_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.exec && opReg == IP_WORD) |=> (ipReg == accReg));

  // R7: no-operation leaves the accumulator alone
  p_nop_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st.stepNop |=> $stable(accReg));

  // R4: IP moves only on boot, execute or no-operation
  p_ip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.bootIp || st.exec || st.stepNop) |=> $stable(ipReg));

endmodule

// File: rtl/rssb_control.sv
module rssb_control
  import rssb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rdIsHalt,
  input  logic        rdIsNop,
  output ctrlStrobe_t st,
  output logic        memWe,
  output logic        halted
);

  typedef enum logic [3:0] {
    S_BOOT_IP,
    S_BOOT_ACC,
    S_BOOT_LATCH,
    S_FETCH,
    S_DECODE,
    S_OPREAD,
    S_EXEC,
    S_SYNC_ACC,
    S_SYNC_IP,
    S_HALT
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_BOOT_IP;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    st         = '0;
    st.addrSel = ADDR_IP;
    st.wdSel   = WD_RES;
    memWe      = 1'b0;
    unique case (state)
      S_BOOT_IP: begin
        st.addrSel = ADDR_IPWORD;
        stateNext  = S_BOOT_ACC;
      end
      S_BOOT_ACC: begin
        st.addrSel = ADDR_ACCWORD;
        st.bootIp  = 1'b1;
        stateNext  = S_BOOT_LATCH;
      end
      S_BOOT_LATCH: begin
        st.bootAcc = 1'b1;
        stateNext  = S_FETCH;
      end
      S_FETCH: begin
        st.addrSel = ADDR_IP;
        stateNext  = S_DECODE;
      end
      S_DECODE: begin
        if (rdIsHalt) begin
          stateNext = S_HALT;
        end else if (rdIsNop) begin
          st.stepNop = 1'b1;
          stateNext  = S_SYNC_IP;
        end else begin
          st.latchOp = 1'b1;
          stateNext  = S_OPREAD;
        end
      end
      S_OPREAD: begin
        st.addrSel = ADDR_OP;
        stateNext  = S_EXEC;
      end
      S_EXEC: begin
        st.exec    = 1'b1;
        st.addrSel = ADDR_OP;
        st.wdSel   = WD_RES;
        memWe      = 1'b1;
        stateNext  = S_SYNC_ACC;
      end
      S_SYNC_ACC: begin
        st.addrSel = ADDR_ACCWORD;
        st.wdSel   = WD_ACC;
        memWe      = 1'b1;
        stateNext  = S_SYNC_IP;
      end
      S_SYNC_IP: begin
        st.addrSel = ADDR_IPWORD;
        st.wdSel   = WD_IP;
        memWe      = 1'b1;
        stateNext  = S_FETCH;
      end
      S_HALT:  stateNext = S_HALT;
      default: stateNext = S_BOOT_IP;
    endcase
  end

  assign halted = (state == S_HALT);

  // R8: halt is sticky
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8: no writes once halted
  p_quiet_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !memWe);

  // R9: word 1 is refreshed right before word 0, and word 0 right before a fetch
  p_sync_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYNC_ACC) |=> (state == S_SYNC_IP && memWe));

endmodule

// File: rtl/rssb_core.sv
module rssb_core
  import rssb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted
);

  ctrlStrobe_t st;
  logic        rdIsHalt, rdIsNop;

  rssb_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdIsHalt (rdIsHalt),
    .rdIsNop  (rdIsNop),
    .st       (st),
    .memWe    (memWe),
    .halted   (halted)
  );

  rssb_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rdIsHalt (rdIsHalt),
    .rdIsNop  (rdIsNop)
  );

  // R1: quiet memory port and low halt flag during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!memWe && !halted);
    end
  end

  // R9: the IP image write-back always targets word 0
  p_ip_image_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && st.wdSel == WD_IP) |-> (memAddr == '0));

endmodule

// File: tb/rssb_core_tb.sv
`timescale 1ns/1ps
module rssb_core_tb;

  localparam int MEM_N = 32;
  localparam logic [15:0] HALT_W = 16'hFFFE;
  localparam logic [15:0] NOP_W  = 16'hFFFF;

  // each entry: {initial ACC, value at operand word 20}
  localparam logic [31:0] VEC [6] = '{
    32'h0003_000A,   // 10-3 = 7, no skip
    32'h000A_0003,   // 3-10 = -7, skip
    32'h0005_0005,   // zero result, no skip
    32'h0001_8000,   // wraps to 7FFF, no skip
    32'hFFFF_7FFF,   // wraps to 8000, skip
    32'h0000_FFFF    // -1, skip
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        memWe, halted;

  logic [15:0] mem [MEM_N];
  logic [15:0] img [MEM_N];
  logic        ldEn = 1'b0;
  logic [4:0]  ldAddr = '0;
  logic [15:0] ldData = '0;

  int checks = 0;
  int errors = 0;
  int haltWrites = 0;

  always #4 clk = ~clk;

  rssb_core u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .halted   (halted)
  );

  always @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (memWe) mem[memAddr[4:0]] <= memWdata;
    memRdata <= mem[memAddr[4:0]];
  end

  always @(posedge clk) begin
    if (rst_n && halted && memWe) haltWrites++;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < MEM_N; i++) img[i] = '0;
  endtask

  task automatic runProg(input string tag);
    rst_n = 1'b0;
    for (int i = 0; i < MEM_N; i++) begin
      @(negedge clk);
      ldEn = 1'b1; ldAddr = 5'(i); ldData = img[i];
    end
    @(negedge clk);
    ldEn = 1'b0;
    // R1: reset state
    check({tag, " R1 halted in reset"}, {15'd0, halted}, 16'd0);
    check({tag, " R1 we in reset"}, {15'd0, memWe}, 16'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 500 && !halted; c++) @(negedge clk);
    check({tag, " R8 halted reached"}, {15'd0, halted}, 16'd1);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // table: single subtract at word 4, halt words on both paths
    for (int v = 0; v < 6; v++) begin
      logic [15:0] a0, m, res, ipExp;
      a0 = VEC[v][31:16];
      m  = VEC[v][15:0];
      res = m - a0;
      ipExp = res[15] ? 16'd6 : 16'd5;
      clearImg();
      img[0] = 16'd4; img[1] = a0; img[4] = 16'd20;
      img[5] = HALT_W; img[6] = HALT_W; img[20] = m;
      runProg($sformatf("vec%0d", v));
      check($sformatf("vec%0d R3 operand word", v), mem[20], res);
      check($sformatf("vec%0d R3 acc word", v), mem[1], res);
      check($sformatf("vec%0d R4 skip ip", v), mem[0], ipExp);
    end

    // R2/R8: boot from word 0/1, immediate halt, quiet afterwards
    clearImg();
    img[0] = 16'd12; img[1] = 16'h1234; img[12] = HALT_W;
    runProg("haltfirst");
    repeat (20) @(negedge clk);
    check("R2 ip from word 0", mem[0], 16'd12);
    check("R2 acc from word 1", mem[1], 16'h1234);
    check("R8 still halted", {15'd0, halted}, 16'd1);
    check("R8 no writes after halt", 16'(haltWrites), 16'd0);

    // R5: operand 1 clears ACC
    clearImg();
    img[0] = 16'd4; img[1] = 16'd123; img[4] = 16'd1; img[5] = HALT_W;
    runProg("accclr");
    check("R5 acc cleared", mem[1], 16'd0);
    check("R5 ip advance", mem[0], 16'd5);

    // R6: operand 0 jumps to result exactly (ip 4 - (-6) = 10)
    clearImg();
    img[0] = 16'd4; img[1] = 16'hFFFA; img[4] = 16'd0;
    img[10] = HALT_W; img[11] = HALT_W;
    runProg("jump");
    check("R6 jump target", mem[0], 16'd10);
    check("R6 acc is result", mem[1], 16'd10);

    // R7: NOP
    clearImg();
    img[0] = 16'd4; img[1] = 16'd7; img[4] = NOP_W; img[5] = HALT_W; img[20] = 16'd33;
    runProg("nop");
    check("R7 ip step", mem[0], 16'd5);
    check("R7 acc kept", mem[1], 16'd7);
    check("R7 memory kept", mem[20], 16'd33);

    // R3/R4: two chained instructions (5-0=5, 12-5=7)
    clearImg();
    img[0] = 16'd4; img[4] = 16'd20; img[5] = 16'd21; img[6] = HALT_W;
    img[20] = 16'd5; img[21] = 16'd12;
    runProg("chain");
    check("R3 chain first", mem[20], 16'd5);
    check("R3 chain second", mem[21], 16'd7);
    check("R4 chain ip", mem[0], 16'd6);

    // R9: jump to word 1 (4-3=1), execute ACC image as operand 1, halt at 2
    clearImg();
    img[0] = 16'd4; img[1] = 16'd3; img[4] = 16'd0; img[2] = HALT_W;
    runProg("execacc");
    check("R9 ip after exec from word 1", mem[0], 16'd2);
    check("R9 acc after exec from word 1", mem[1], 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule